// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the hardware side of taking an exception in a CPU core. A request arrives with a type code, the PC of the faulting instruction, a flag for a fault in a delay slot, the address of the branch that owns that slot, and the faulting virtual address. In the cycle the request is taken, the block does three things. It saves the return context into shadow registers. It issues a new status register value with the privileged-mode, exception-block and register-bank bits set. It redirects fetch to the vector base plus 0x100, and it pulses a pipeline flush in that same cycle.

A request flagged as a TLB multiple-hit fault takes a reset-style path. It records the address and a fixed cause code, and it redirects fetch to a fixed reset address. It leaves the saved context and the status register untouched. A general request that arrives while the exception-block bit is set is held as pending until that bit clears. A return input puts the saved context back: the status value, the R15 value and the return address.

The status register and R15 are kept by the core. This block reads them on `sr_i` and `r15_i`, and it asks for writes through `sr_we_o` and `r15_we_o`. Status bit positions: 30 selects privileged mode, 29 selects the register bank, 28 blocks exceptions.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and after it is released, `spc_o`, `ssr_o`, `sgr_o`, `tea_o` and `expevt_o` read 0, and `redirect_valid_o`, `flush_o`, `sr_we_o`, `r15_we_o` and `pending_o` are 0.
- R2: A general request taken with bit 28 of `sr_i` at 0 drives `redirect_valid_o` and `flush_o` high in that cycle, with `redirect_pc_o` = `vbr_i` + 0x100. From the next cycle, `expevt_o` holds the request code and `tea_o` holds the request virtual address.
- R3: On a taken general request, `spc_o` takes `req_pc_i` when `req_slot_i` is 0, and takes `req_branch_pc_i` when `req_slot_i` is 1.
- R4: On a taken general request, `ssr_o` takes the `sr_i` value and `sgr_o` takes the `r15_i` value of the accepting cycle.
- R5: On a taken general request, `sr_we_o` is 1 and `sr_o` equals `sr_i` with bits 30, 29 and 28 set to 1, in the same cycle.
- R6: A general request seen while bit 28 of `sr_i` is 1 is held, and `pending_o` is 1 from the next cycle. It is taken in the first cycle in which bit 28 reads 0. Its code, saved PC and address are those given when it arrived.
- R7: A general request that arrives while a request is already pending is ignored. Only the earlier request is later taken.
- R8: A request with `req_mhit_i` = 1 is taken even when bit 28 is 1. It redirects to 0xA000_0000 with a flush, and from the next cycle `expevt_o` = 0x140 and `tea_o` holds its address. `spc_o`, `ssr_o` and `sgr_o` keep their values, and `sr_we_o` stays 0.
- R9: `rte_i` with no request being taken drives a redirect to `spc_o` with a flush. In the same cycle it asserts `sr_we_o` with `sr_o` = `ssr_o`, and `r15_we_o` with `r15_o` = `sgr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Exception request strobe |
| req_mhit_i | input | 1 | Request is a TLB multiple-hit fault |
| req_code_i | input | 12 | Exception type code |
| req_pc_i | input | 32 | PC of the faulting instruction |
| req_slot_i | input | 1 | Fault lies in a delay slot |
| req_branch_pc_i | input | 32 | PC of the delayed branch owning the slot |
| req_vaddr_i | input | 32 | Faulting virtual address |
| rte_i | input | 1 | Return from exception |
| sr_i | input | 32 | Current status register |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base register |
| sr_we_o | output | 1 | Status register write enable |
| sr_o | output | 32 | Status register write value |
| r15_we_o | output | 1 | R15 write enable |
| r15_o | output | 32 | R15 write value |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| flush_o | output | 1 | Pipeline flush pulse |
| pending_o | output | 1 | A blocked request is being held |
| spc_o | output | 32 | Saved return PC |
| ssr_o | output | 32 | Saved status |
| sgr_o | output | 32 | Saved R15 |
| tea_o | output | 32 | Recorded faulting address |
| expevt_o | output | 12 | Recorded exception code |

## Verification
The assertions assume that a return never shares a cycle with a request, and that the core writes `sr_o` into the status register on the clock edge after `sr_we_o`. The assertions key off the status write itself to tell general entries from returns. The bench models the core's status register and feeds it back on `sr_i`. It keeps each return apart from any request. It changes `r15_i` on every cycle, so that a stale saved R15 value shows up.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned MD_BIT = 30;
  localparam int unsigned RB_BIT = 29;
  localparam int unsigned BL_BIT = 28;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   ret_pc;
    logic [XLEN-1:0]   vaddr;
  } exc_rec_t;
endpackage

// File: rtl/exc_pend.sv
module exc_pend
  import exc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     live_gen_i,
  input  exc_rec_t live_rec_i,
  input  logic     bl_i,
  input  logic     hold_i,
  output logic     go_o,
  output exc_rec_t rec_o,
  output logic     pend_o
);
  logic     pend_q;
  exc_rec_t pend_rec_q;

  assign go_o   = ~bl_i & ~hold_i & (pend_q | live_gen_i);
  assign rec_o  = pend_q ? pend_rec_q : live_rec_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_rec_q <= '0;
    end else if (go_o) begin
      pend_q     <= 1'b0;
    end else if (live_gen_i && !pend_q) begin
      pend_q     <= 1'b1;
      pend_rec_q <= live_rec_i;
    end
  end
endmodule

// File: rtl/exc_ctx.sv
module exc_ctx
  import exc_pkg::*;
#(
  parameter logic [CODE_W-1:0] MHIT_CODE = 12'h140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_go_i,
  input  logic              mh_go_i,
  input  exc_rec_t          rec_i,
  input  logic [XLEN-1:0]   mh_vaddr_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   tea_o,
  output logic [CODE_W-1:0] expevt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_o    <= '0;
      ssr_o    <= '0;
      sgr_o    <= '0;
      tea_o    <= '0;
      expevt_o <= '0;
    end else if (mh_go_i) begin
      tea_o    <= mh_vaddr_i;
      expevt_o <= MHIT_CODE;
    end else if (gen_go_i) begin
      spc_o    <= rec_i.ret_pc;
      ssr_o    <= sr_i;
      sgr_o    <= r15_i;
      tea_o    <= rec_i.vaddr;
      expevt_o <= rec_i.code;
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] GEN_OFFSET = 32'h0000_0100,
  parameter logic [XLEN-1:0] MHIT_VEC   = 32'hA000_0000
) (
  input  logic            mh_go_i,
  input  logic            gen_go_i,
  input  logic            rte_i,
  input  logic [XLEN-1:0] vbr_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] spc_i,
  input  logic [XLEN-1:0] ssr_i,
  input  logic [XLEN-1:0] sgr_i,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            sr_we_o,
  output logic [XLEN-1:0] sr_o,
  output logic            r15_we_o,
  output logic [XLEN-1:0] r15_o
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << MD_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << BL_BIT);

  logic ret_go;
  assign ret_go = rte_i & ~mh_go_i & ~gen_go_i;

  always_comb begin
    redirect_valid_o = mh_go_i | gen_go_i | ret_go;
    redirect_pc_o    = spc_i;
    sr_we_o          = gen_go_i | ret_go;
    sr_o             = ssr_i;
    r15_we_o         = ret_go;
    r15_o            = sgr_i;
    if (mh_go_i) begin
      redirect_pc_o = MHIT_VEC;
    end else if (gen_go_i) begin
      redirect_pc_o = vbr_i + GEN_OFFSET;
      sr_o          = sr_i | ENTRY_SET;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0]   GEN_OFFSET = 32'h0000_0100,
  parameter logic [XLEN-1:0]   MHIT_VEC   = 32'hA000_0000,
  parameter logic [CODE_W-1:0] MHIT_CODE  = 12'h140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_mhit_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic [XLEN-1:0]   req_pc_i,
  input  logic              req_slot_i,
  input  logic [XLEN-1:0]   req_branch_pc_i,
  input  logic [XLEN-1:0]   req_vaddr_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic              sr_we_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              r15_we_o,
  output logic [XLEN-1:0]   r15_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              flush_o,
  output logic              pending_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   tea_o,
  output logic [CODE_W-1:0] expevt_o
);
  logic     live_gen, live_mh, gen_go;
  exc_rec_t live_rec, sel_rec;

  assign live_gen        = req_valid_i & ~req_mhit_i;
  assign live_mh         = req_valid_i & req_mhit_i;
  assign live_rec.code   = req_code_i;
  assign live_rec.ret_pc = req_slot_i ? req_branch_pc_i : req_pc_i;
  assign live_rec.vaddr  = req_vaddr_i;

  exc_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .live_gen_i (live_gen),
    .live_rec_i (live_rec),
    .bl_i       (sr_i[BL_BIT]),
    .hold_i     (live_mh),
    .go_o       (gen_go),
    .rec_o      (sel_rec),
    .pend_o     (pending_o)
  );

  exc_ctx #(.MHIT_CODE(MHIT_CODE)) u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gen_go_i   (gen_go),
    .mh_go_i    (live_mh),
    .rec_i      (sel_rec),
    .mh_vaddr_i (req_vaddr_i),
    .sr_i       (sr_i),
    .r15_i      (r15_i),
    .spc_o      (spc_o),
    .ssr_o      (ssr_o),
    .sgr_o      (sgr_o),
    .tea_o      (tea_o),
    .expevt_o   (expevt_o)
  );

  exc_target #(.GEN_OFFSET(GEN_OFFSET), .MHIT_VEC(MHIT_VEC)) u_tgt (
    .mh_go_i          (live_mh),
    .gen_go_i         (gen_go),
    .rte_i            (rte_i),
    .vbr_i            (vbr_i),
    .sr_i             (sr_i),
    .spc_i            (spc_o),
    .ssr_i            (ssr_o),
    .sgr_i            (sgr_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .sr_we_o          (sr_we_o),
    .sr_o             (sr_o),
    .r15_we_o         (r15_we_o),
    .r15_o            (r15_o)
  );

  assign flush_o = redirect_valid_o;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0]   GEN_OFFSET = 32'h0000_0100,
  parameter logic [XLEN-1:0]   MHIT_VEC   = 32'hA000_0000,
  parameter logic [CODE_W-1:0] MHIT_CODE  = 12'h140
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_mhit_i,
  input logic [XLEN-1:0]   req_vaddr_i,
  input logic              rte_i,
  input logic [XLEN-1:0]   sr_i,
  input logic [XLEN-1:0]   r15_i,
  input logic [XLEN-1:0]   vbr_i,
  input logic              sr_we_o,
  input logic [XLEN-1:0]   sr_o,
  input logic              r15_we_o,
  input logic [XLEN-1:0]   r15_o,
  input logic              redirect_valid_o,
  input logic [XLEN-1:0]   redirect_pc_o,
  input logic              flush_o,
  input logic              pending_o,
  input logic [XLEN-1:0]   spc_o,
  input logic [XLEN-1:0]   ssr_o,
  input logic [XLEN-1:0]   sgr_o,
  input logic [XLEN-1:0]   tea_o,
  input logic [CODE_W-1:0] expevt_o
);
  AST_GEN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_o && !r15_we_o) |-> (sr_o[MD_BIT] && sr_o[RB_BIT] && sr_o[BL_BIT]
      && redirect_valid_o && flush_o && redirect_pc_o == vbr_i + GEN_OFFSET)); // R5

  AST_CTX_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_o && !r15_we_o) |=> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i))); // R4

  AST_BL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_i[BL_BIT] && !rte_i) |-> !sr_we_o); // R6

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && sr_i[BL_BIT]) |=> pending_o); // R6

  AST_MHIT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mhit_i) |-> (redirect_valid_o && flush_o
      && redirect_pc_o == MHIT_VEC && !sr_we_o)); // R8

  AST_MHIT_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mhit_i) |=> (expevt_o == MHIT_CODE && tea_o == $past(req_vaddr_i)
      && $stable(spc_o) && $stable(ssr_o) && $stable(sgr_o))); // R8

  AST_RTE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i && !req_valid_i && (!pending_o || sr_i[BL_BIT])) |->
      (redirect_valid_o && redirect_pc_o == spc_o && sr_we_o && sr_o == ssr_o
       && r15_we_o && r15_o == sgr_o)); // R9

  AST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !rte_i && !pending_o) |-> (!redirect_valid_o && !flush_o)); // R2
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .GEN_OFFSET(GEN_OFFSET), .MHIT_VEC(MHIT_VEC), .MHIT_CODE(MHIT_CODE)
) u_chk (.*);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_mhit_i = 1'b0, req_slot_i = 1'b0, rte_i = 1'b0;
  logic [11:0] req_code_i = '0;
  logic [31:0] req_pc_i = '0, req_branch_pc_i = '0, req_vaddr_i = '0;
  logic [31:0] sr_i, r15_i = '0, vbr_i = 32'h8C00_0000;
  logic        sr_we_o, r15_we_o, redirect_valid_o, flush_o, pending_o;
  logic [31:0] sr_o, r15_o, redirect_pc_o, spc_o, ssr_o, sgr_o, tea_o;
  logic [11:0] expevt_o;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] core_sr = 32'h0000_00F0;
  // reference state
  bit          m_pend = 0;
  logic [11:0] m_pcode = '0, m_expevt = '0;
  logic [31:0] m_pspc = '0, m_pva = '0;
  logic [31:0] m_spc = '0, m_ssr = '0, m_sgr = '0, m_tea = '0;

  assign sr_i = core_sr;

  always #4 clk_i = ~clk_i;

  exc_entry_seq u_exc_entry_seq (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      report();
    end
  end

  task automatic cyc(string tag, bit v, bit mh, logic [11:0] code, logic [31:0] pc,
                     bit slot, logic [31:0] bpc, logic [31:0] va, bit rte);
    bit          live_mh, live_gen, bl, e_go, e_ret, e_rv, e_srwe;
    logic [11:0] r_code;
    logic [31:0] r_spc, r_va, e_pc, e_sr, r15_now;
    req_valid_i = v; req_mhit_i = mh; req_code_i = code; req_pc_i = pc;
    req_slot_i = slot; req_branch_pc_i = bpc; req_vaddr_i = va; rte_i = rte;
    r15_i = 32'h1500_0000 + 32'(cycles * 7);
    r15_now = r15_i;
    #1;
    live_mh  = v && mh;
    live_gen = v && !mh;
    bl       = core_sr[28];
    e_go     = !bl && !live_mh && (m_pend || live_gen);
    e_ret    = rte && !live_mh && !e_go;
    r_code   = m_pend ? m_pcode : code;
    r_spc    = m_pend ? m_pspc : (slot ? bpc : pc);
    r_va     = m_pend ? m_pva : va;
    e_rv     = live_mh || e_go || e_ret;
    e_pc     = live_mh ? 32'hA000_0000 : (e_go ? vbr_i + 32'h100 : m_spc);
    e_srwe   = e_go || e_ret;
    e_sr     = e_go ? (core_sr | 32'h7000_0000) : m_ssr;
    chk({tag, " R2 redirect_valid"}, 32'(redirect_valid_o), 32'(e_rv));
    chk({tag, " R2 flush"}, 32'(flush_o), 32'(e_rv));
    if (e_rv) chk({tag, " R2/R8/R9 redirect_pc"}, redirect_pc_o, e_pc);
    chk({tag, " R5 sr_we"}, 32'(sr_we_o), 32'(e_srwe));
    if (e_srwe) chk({tag, " R5/R9 sr_o"}, sr_o, e_sr);
    chk({tag, " R9 r15_we"}, 32'(r15_we_o), 32'(e_ret));
    if (e_ret) chk({tag, " R9 r15_o"}, r15_o, m_sgr);
    chk({tag, " R6 pending"}, 32'(pending_o), 32'(m_pend));
    @(negedge clk_i);
    if (live_mh) begin
      m_tea = va; m_expevt = 12'h140;
    end else if (e_go) begin
      m_spc = r_spc; m_ssr = core_sr; m_sgr = r15_now; m_tea = r_va; m_expevt = r_code;
    end
    if (e_go) m_pend = 0;
    else if (live_gen && !m_pend) begin
      m_pend = 1; m_pcode = code; m_pspc = slot ? bpc : pc; m_pva = va;
    end
    if (e_srwe) core_sr = e_sr;
    chk({tag, " R3 spc"}, spc_o, m_spc);
    chk({tag, " R4 ssr"}, ssr_o, m_ssr);
    chk({tag, " R4 sgr"}, sgr_o, m_sgr);
    chk({tag, " R2 tea"}, tea_o, m_tea);
    chk({tag, " R2 expevt"}, 32'(expevt_o), 32'(m_expevt));
    req_valid_i = 0; rte_i = 0;
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, '0, '0, 0, '0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk("R1 spc in reset", spc_o, 0);
    chk("R1 expevt in reset", 32'(expevt_o), 0);
    chk("R1 redirect in reset", 32'(redirect_valid_o), 0);
    chk("R1 pending in reset", 32'(pending_o), 0);
    rst_ni = 1'b1;
    idle("R1 idle");
    // R2 R3: general entry, not in a slot
    cyc("R2 gen", 1, 0, 12'h0A0, 32'h8C00_1000, 0, 32'h8C00_0FFC, 32'h0040_0010, 0);
    idle("R5 after entry");
    cyc("R9 rte", 0, 0, '0, '0, 0, '0, '0, 1);
    // R3: delay slot saves the branch address
    cyc("R3 slot", 1, 0, 12'h0E0, 32'h8C00_2002, 1, 32'h8C00_2000, 32'h0050_0000, 0);
    cyc("R9 rte2", 0, 0, '0, '0, 0, '0, '0, 1);
    // R8: multiple hit with exceptions unblocked
    cyc("R8 mhit", 1, 1, 12'h0A0, 32'h8C00_3000, 0, '0, 32'h0060_0123, 0);
    // R6: entry sets BL, next request is held
    cyc("R6 first", 1, 0, 12'h0A0, 32'h8C00_4000, 0, '0, 32'h0070_0000, 0);
    cyc("R6 held", 1, 0, 12'h0C0, 32'h8C00_5004, 1, 32'h8C00_5000, 32'h0080_0000, 0);
    idle("R6 wait");
    // R7: second request while pending is dropped
    cyc("R7 drop", 1, 0, 12'h100, 32'h8C00_6000, 0, '0, 32'h0090_0000, 0);
    // R8: multiple hit taken even while BL is set, pending kept
    cyc("R8 mhit bl", 1, 1, '0, '0, 0, '0, 32'h00A0_0456, 0);
    cyc("R9 rte3", 0, 0, '0, '0, 0, '0, '0, 1);
    idle("R6 pending taken");
    idle("R7 no second");
    cyc("R9 rte4", 0, 0, '0, '0, 0, '0, '0, 1);
    vbr_i = 32'h8800_0000;
    cyc("R2 new vbr", 1, 0, 12'h160, 32'h8C00_7000, 0, '0, 32'h00B0_0000, 0);
    idle("R2 tail");
    report();
  end
endmodule